// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Service and Vector Unit

This block collects the receive, transmit and break interrupt conditions of two serial channels, A and B. It keeps each channel's pending flags and a small service state machine, drives one interrupt line to the host, and maintains an 8-bit vector register and an 8-bit pending-bit register for the host to read. Channel-side logic pulses single-cycle events into it: character received, transmit buffer emptied, break detected, host read of the data port and host write of the data port. Host commands arrive as single-cycle pulses too: clear the transmit interrupt, and reset the highest under-service level. Enable fields decoded from the host's write registers are held as level inputs.

Each channel runs a four-state service machine whose states record which request is currently in service. S_IDLE has nothing in service. S_TX has a transmit request in service. S_RX has a receive request in service. S_RX_TX has a receive request that arrived while a transmit request was in service. A receive event moves S_IDLE to S_RX and S_TX to S_RX_TX. A transmit event moves S_IDLE to S_TX, but only when no receive is in service. A data read or a reset-under-service command ends receive service, moving S_RX to S_IDLE and S_RX_TX to S_TX. If a transmit interrupt is still pending at that point, S_RX goes to S_TX instead. A clear-transmit command moves S_TX to S_IDLE and S_RX_TX to S_RX. When a receive interrupt is still pending, that same command re-enters receive service. When no receive is in service, a reset-under-service command moves S_TX to S_IDLE.

Both channels write into one shared vector register. The code written depends on the status-high select input.

Top module: `irqv_top`

## Requirements
- R1: While reset is asserted and on leaving reset, `irq` is 0, `vec` is 0x00 and `pend` is 0x00.
- R2: A channel requests an interrupt when any of these holds: its transmit enable is 1 and its transmit interrupt is pending; its 2-bit receive mode is 01 or 10 and its receive interrupt is pending; its break enable is 1 and its break status is set. Receive modes 00 and 11 never request. `irq` is the OR of both channel requests and follows the enable inputs combinationally.
- R3: A receive event sets receive-pending and places receive in service, both in one cycle. It also sets the channel's receive bit in `pend`, with channel A at bit 5 and channel B at bit 2. It writes the channel's receive code to `vec`.
- R4: A transmit event sets transmit-pending. If no receive is in service, it also places transmit in service and writes the channel's transmit code to `vec`. In that case it sets the transmit bit in `pend` only when transmit enable is 1, with channel A at bit 4 and channel B at bit 1. If a receive is in service, `vec` and `pend` are left unchanged.
- R5: Vector codes with `status_hi`=1 are: no interrupt 0x60, A receive 0x30, B receive 0x20, A transmit 0x10, B transmit 0x00. With `status_hi`=0 they are: no interrupt 0x06, A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00.
- R6: Both channels write the single `vec` register. If both channels write in the same cycle, channel A's code is kept.
- R7: Reset-under-service first acts on receive. If receive is in service, it ends receive service; if transmit is still pending, it re-raises transmit as in R4. Only when no receive is in service does it end transmit service.
- R8: A data read clears receive-pending, receive service and the receive bit in `pend`, and writes the no-interrupt code. It then re-raises a still-pending transmit interrupt as in R4.
- R9: Clear-transmit clears transmit-pending, transmit service and the transmit bit in `pend`, and writes the no-interrupt code. It then re-raises a still-pending receive interrupt as in R3.
- R10: A data write clears transmit-pending only; `vec` and the transmit bit in `pend` keep their values.
- R11: A break event sets a break status that stays set until reset. The channel's external bit in `pend` (A at bit 3, B at bit 0) is the break status ANDed with that channel's break enable. Bits 7:6 of `pend` read 0.
- R12: When several event or command inputs of one channel pulse in the same cycle, only one is applied. The order, from highest priority, is: receive, data read, transmit empty, data write, clear-transmit, reset-under-service. Break events are applied independently of this order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rdy | input | 2 | Character-received pulse, bit 0 channel A, bit 1 channel B |
| rd_strb | input | 2 | Host data-port read pulse, per channel |
| tx_mt | input | 2 | Transmit-buffer-empty pulse, per channel |
| wr_strb | input | 2 | Host data-port write pulse, per channel |
| clr_tx_cmd | input | 2 | Clear-transmit-interrupt command pulse, per channel |
| rst_svc_cmd | input | 2 | Reset-highest-under-service command pulse, per channel |
| brk_det | input | 2 | Break-detected pulse, per channel |
| tx_ie | input | 2 | Transmit interrupt enable, per channel |
| rx_mode | input | 4 | Receive interrupt mode, bits 1:0 channel A, bits 3:2 channel B |
| brk_ie | input | 2 | Break interrupt enable, per channel |
| status_hi | input | 1 | Selects the high vector encoding |
| irq | output | 1 | Interrupt request to the host |
| vec | output | 8 | Shared vector register |
| pend | output | 8 | Pending-bit register |

## Verification
The bench exercises the preemption corner, where a transmit event arrives while a receive is in service. A design that let transmit into service there would overwrite the receive vector and set the transmit pending bit too early. It also checks both re-raise paths, data read re-raising transmit and clear-transmit re-raising receive; a design missing either would leave the vector on the no-interrupt code while `irq` stays high. Other targets are a same-cycle write from both channels, where channel B's code must not win, and the receive modes 00 and 11, which must not raise `irq` even though the pending bit is set. Finally, the bench pulses conflicting events together. A design that applied the wrong event would leave transmit pending when it should not, or the reverse, and that shows on `irq`.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;
    localparam int VEC_W  = 8;
    localparam int PEND_W = 8;
    localparam int NUM_CH = 2;

    // Service state: bit 1 = receive in service, bit 0 = transmit in service
    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_TX    = 2'b01,
        S_RX    = 2'b10,
        S_RX_TX = 2'b11
    } svc_e;

    typedef enum logic [2:0] {
        E_NONE,
        E_RX,
        E_RD,
        E_TXE,
        E_WR,
        E_CLRTX,
        E_RST
    } evt_e;

    typedef enum logic [1:0] {
        K_HOLD,
        K_NONE,
        K_RX,
        K_TX
    } kind_e;

    function automatic logic [VEC_W-1:0] vec_code(input logic chan_b, input kind_e k, input logic hi);
        logic [VEC_W-1:0] c;
        c = '0;
        unique case (k)
            K_NONE:  c = hi ? VEC_W'(8'h60) : VEC_W'(8'h06);
            K_RX:    c = chan_b ? (hi ? VEC_W'(8'h20) : VEC_W'(8'h04))
                                : (hi ? VEC_W'(8'h30) : VEC_W'(8'h0C));
            K_TX:    c = chan_b ? VEC_W'(8'h00)
                                : (hi ? VEC_W'(8'h10) : VEC_W'(8'h08));
            default: c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/irqv_chan.sv
`timescale 1ns/1ps
module irqv_chan
    import irqv_pkg::*;
#(
    parameter bit CHAN_B = 1'b0,
    parameter int VW     = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_rx,
    input  logic          ev_rd,
    input  logic          ev_txe,
    input  logic          ev_wr,
    input  logic          ev_clrtx,
    input  logic          ev_rst,
    input  logic          ev_brk,
    input  logic          tx_ie,
    input  logic [1:0]    rx_mode,
    input  logic          brk_ie,
    input  logic          status_hi,
    output logic          req,
    output logic          vec_we,
    output logic [VW-1:0] vec_val,
    output logic          pend_rx,
    output logic          pend_tx,
    output logic          pend_ext
);
    svc_e  st, st_nxt;
    evt_e  ev;
    kind_e kind;

    logic rx_pend, tx_pend, prx_q, ptx_q, brk_q;
    logic n_rx_pend, n_tx_pend, n_prx, n_ptx;
    logic rx_ius, tx_ius, n_rx_ius, n_tx_ius;

    // Event selection, highest priority first (R12)
    always_comb begin
        if (ev_rx)         ev = E_RX;
        else if (ev_rd)    ev = E_RD;
        else if (ev_txe)   ev = E_TXE;
        else if (ev_wr)    ev = E_WR;
        else if (ev_clrtx) ev = E_CLRTX;
        else if (ev_rst)   ev = E_RST;
        else               ev = E_NONE;
    end

    // Next-state and flag logic
    always_comb begin
        unique case (st)
            S_IDLE:  begin rx_ius = 1'b0; tx_ius = 1'b0; end
            S_TX:    begin rx_ius = 1'b0; tx_ius = 1'b1; end
            S_RX:    begin rx_ius = 1'b1; tx_ius = 1'b0; end
            S_RX_TX: begin rx_ius = 1'b1; tx_ius = 1'b1; end
            default: begin rx_ius = 1'b0; tx_ius = 1'b0; end
        endcase

        n_rx_ius  = rx_ius;
        n_tx_ius  = tx_ius;
        n_rx_pend = rx_pend;
        n_tx_pend = tx_pend;
        n_prx     = prx_q;
        n_ptx     = ptx_q;
        kind      = K_HOLD;

        unique case (ev)
            E_RX: begin
                n_rx_pend = 1'b1;
                n_rx_ius  = 1'b1;
                n_prx     = 1'b1;
                kind      = K_RX;
            end
            E_RD: begin
                n_rx_pend = 1'b0;
                n_rx_ius  = 1'b0;
                n_prx     = 1'b0;
                kind      = K_NONE;
                if (tx_pend) begin
                    n_tx_ius = 1'b1;
                    n_ptx    = prx_q ? (ptx_q | tx_ie) : (ptx_q | tx_ie);
                    kind     = K_TX;
                end
            end
            E_TXE: begin
                n_tx_pend = 1'b1;
                if (!rx_ius) begin
                    n_tx_ius = 1'b1;
                    n_ptx    = ptx_q | tx_ie;
                    kind     = K_TX;
                end
            end
            E_WR: begin
                n_tx_pend = 1'b0;
            end
            E_CLRTX: begin
                n_tx_pend = 1'b0;
                n_tx_ius  = 1'b0;
                n_ptx     = 1'b0;
                kind      = K_NONE;
                if (rx_pend) begin
                    n_rx_ius = 1'b1;
                    n_prx    = 1'b1;
                    kind     = K_RX;
                end
            end
            E_RST: begin
                if (rx_ius) begin
                    n_rx_ius = 1'b0;
                    if (tx_pend) begin
                        n_tx_ius = 1'b1;
                        n_ptx    = ptx_q | tx_ie;
                        kind     = K_TX;
                    end
                end else if (tx_ius) begin
                    n_tx_ius = 1'b0;
                end
            end
            default: ;
        endcase

        unique case ({n_rx_ius, n_tx_ius})
            2'b00:   st_nxt = S_IDLE;
            2'b01:   st_nxt = S_TX;
            2'b10:   st_nxt = S_RX;
            default: st_nxt = S_RX_TX;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            rx_pend <= 1'b0;
            tx_pend <= 1'b0;
            prx_q   <= 1'b0;
            ptx_q   <= 1'b0;
            brk_q   <= 1'b0;
        end else begin
            st      <= st_nxt;
            rx_pend <= n_rx_pend;
            tx_pend <= n_tx_pend;
            prx_q   <= n_prx;
            ptx_q   <= n_ptx;
            brk_q   <= brk_q | ev_brk;
        end
    end

    // Outputs
    always_comb begin
        vec_we   = (kind != K_HOLD);
        vec_val  = vec_code(CHAN_B, kind, status_hi);
        pend_rx  = prx_q;
        pend_tx  = ptx_q;
        pend_ext = brk_q & brk_ie;
        req      = (tx_ie & tx_pend)
                 | (((rx_mode == 2'b01) || (rx_mode == 2'b10)) & rx_pend)
                 | (brk_ie & brk_q);
    end

    // Assertions
    p_rx_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == E_RX) |=> ((st == S_RX) || (st == S_RX_TX)) && rx_pend && pend_rx);

    p_tx_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == E_TXE) && rx_ius |=> (st == $past(st)) && tx_pend && $stable(pend_tx));

    p_rst_tx_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == E_RST) && (st == S_TX) |=> (st == S_IDLE));

    p_rd_reraise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == E_RD) && tx_pend |=> (st == S_TX) && !rx_pend);

    p_clrtx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == E_CLRTX) && !rx_pend |=> !tx_pend && !pend_tx && ((st == S_IDLE) || (st == S_RX)));

    p_wr_keeps_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == E_WR) |=> !tx_pend && $stable(pend_tx) && $stable(st));

    p_brk_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |=> brk_q);
endmodule

// File: rtl/irqv_vecreg.sv
`timescale 1ns/1ps
module irqv_vecreg
    import irqv_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [VW-1:0] val_a,
    input  logic          we_b,
    input  logic [VW-1:0] val_b,
    output logic [VW-1:0] vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vec <= '0;
        else if (we_a) vec <= val_a;
        else if (we_b) vec <= val_b;
    end

    p_a_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_a && we_b |=> (vec == $past(val_a)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_a && !we_b |=> $stable(vec));
endmodule

// File: rtl/irqv_top.sv
`timescale 1ns/1ps
module irqv_top
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rx_rdy,
    input  logic [1:0]        rd_strb,
    input  logic [1:0]        tx_mt,
    input  logic [1:0]        wr_strb,
    input  logic [1:0]        clr_tx_cmd,
    input  logic [1:0]        rst_svc_cmd,
    input  logic [1:0]        brk_det,
    input  logic [1:0]        tx_ie,
    input  logic [3:0]        rx_mode,
    input  logic [1:0]        brk_ie,
    input  logic              status_hi,
    output logic              irq,
    output logic [VEC_W-1:0]  vec,
    output logic [PEND_W-1:0] pend
);
    logic [NUM_CH-1:0] req, we, prx, ptx, pext;
    logic [VEC_W-1:0]  cv [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        irqv_chan #(.CHAN_B(g == 1), .VW(VEC_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_rx     (rx_rdy[g]),
            .ev_rd     (rd_strb[g]),
            .ev_txe    (tx_mt[g]),
            .ev_wr     (wr_strb[g]),
            .ev_clrtx  (clr_tx_cmd[g]),
            .ev_rst    (rst_svc_cmd[g]),
            .ev_brk    (brk_det[g]),
            .tx_ie     (tx_ie[g]),
            .rx_mode   (rx_mode[2*g +: 2]),
            .brk_ie    (brk_ie[g]),
            .status_hi (status_hi),
            .req       (req[g]),
            .vec_we    (we[g]),
            .vec_val   (cv[g]),
            .pend_rx   (prx[g]),
            .pend_tx   (ptx[g]),
            .pend_ext  (pext[g])
        );
    end

    irqv_vecreg #(.VW(VEC_W)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .we_a  (we[0]),
        .val_a (cv[0]),
        .we_b  (we[1]),
        .val_b (cv[1]),
        .vec   (vec)
    );

    assign irq  = |req;
    assign pend = {{(PEND_W-6){1'b0}}, prx[0], ptx[0], pext[0], prx[1], ptx[1], pext[1]};

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie == 2'b00) && (brk_ie == 2'b00)
        && (rx_mode[1:0] != 2'b01) && (rx_mode[1:0] != 2'b10)
        && (rx_mode[3:2] != 2'b01) && (rx_mode[3:2] != 2'b10) |-> !irq);

    p_pend_hi_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pend[PEND_W-1:6] == '0);
endmodule

// File: tb/sim_irqv_top.sv
`timescale 1ns/1ps
module sim_irqv_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] rx_rdy, rd_strb, tx_mt, wr_strb, clr_tx_cmd, rst_svc_cmd, brk_det;
    logic [1:0] tx_ie, brk_ie;
    logic [3:0] rx_mode;
    logic       status_hi;
    logic       irq;
    logic [7:0] vec, pend;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irqv_top u0 (
        .clk(clk), .rst_n(rst_n), .rx_rdy(rx_rdy), .rd_strb(rd_strb), .tx_mt(tx_mt),
        .wr_strb(wr_strb), .clr_tx_cmd(clr_tx_cmd), .rst_svc_cmd(rst_svc_cmd),
        .brk_det(brk_det), .tx_ie(tx_ie), .rx_mode(rx_mode), .brk_ie(brk_ie),
        .status_hi(status_hi), .irq(irq), .vec(vec), .pend(pend)
    );

    // Event encoding per channel: rx, rd, txe, wr, clrtx, rst, brk
    localparam logic [6:0] N   = 7'b0000000;
    localparam logic [6:0] RX  = 7'b1000000;
    localparam logic [6:0] RD  = 7'b0100000;
    localparam logic [6:0] TXE = 7'b0010000;
    localparam logic [6:0] WR  = 7'b0001000;
    localparam logic [6:0] CLR = 7'b0000100;
    localparam logic [6:0] RST = 7'b0000010;
    localparam logic [6:0] BRK = 7'b0000001;

    // {evA, evB, status_hi, exp_irq, exp_vec, exp_pend}; tx_ie=11, rx_mode A=01 B=10
    localparam int NT = 21;
    localparam logic [31:0] TBL [NT] = '{
        {RX,      N,   1'b0, 1'b1, 8'h0C, 8'h20},  // R3 A receive
        {TXE,     N,   1'b0, 1'b1, 8'h0C, 8'h20},  // R4 transmit blocked by receive service
        {RD,      N,   1'b0, 1'b1, 8'h08, 8'h10},  // R8 read re-raises transmit
        {WR,      N,   1'b0, 1'b0, 8'h08, 8'h10},  // R10 write drops pending only
        {TXE,     N,   1'b0, 1'b1, 8'h08, 8'h10},  // R4 transmit enters
        {CLR,     N,   1'b0, 1'b0, 8'h06, 8'h00},  // R9 clear transmit
        {N,       RX,  1'b1, 1'b1, 8'h20, 8'h04},  // R5 B receive, high codes
        {N,       TXE, 1'b1, 1'b1, 8'h20, 8'h04},  // R4 blocked on B
        {N,       RST, 1'b1, 1'b1, 8'h00, 8'h06},  // R7 receive ends, transmit re-raised
        {N,       CLR, 1'b1, 1'b1, 8'h20, 8'h04},  // R9 clear transmit re-raises receive
        {N,       RD,  1'b1, 1'b0, 8'h60, 8'h00},  // R8 read, no transmit pending
        {RX,      RX,  1'b0, 1'b1, 8'h0C, 8'h24},  // R6 channel A wins vector
        {RD,      RD,  1'b1, 1'b0, 8'h60, 8'h00},  // R6 both write no-interrupt code
        {RX | RD, N,   1'b1, 1'b1, 8'h30, 8'h20},  // R12 receive beats read
        {RD,      N,   1'b1, 1'b0, 8'h60, 8'h00},  // R8
        {TXE,     N,   1'b0, 1'b1, 8'h08, 8'h10},  // R4
        {RST,     N,   1'b0, 1'b1, 8'h08, 8'h10},  // R7 ends transmit service only
        {RX,      N,   1'b0, 1'b1, 8'h0C, 8'h30},  // R3
        {RST,     N,   1'b0, 1'b1, 8'h08, 8'h30},  // R7 receive first, transmit re-raised
        {RD,      N,   1'b0, 1'b1, 8'h08, 8'h10},  // R8
        {CLR,     N,   1'b0, 1'b0, 8'h06, 8'h00}   // R9
    };

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic ei, input logic [7:0] ev, input logic [7:0] ep);
        chk(tag, "irq", {7'b0, irq}, {7'b0, ei});
        chk(tag, "vec", vec, ev);
        chk(tag, "pend", pend, ep);
    endtask

    task automatic step(input logic [6:0] ea, input logic [6:0] eb, input logic hi);
        status_hi = hi;
        {rx_rdy[0], rd_strb[0], tx_mt[0], wr_strb[0], clr_tx_cmd[0], rst_svc_cmd[0], brk_det[0]} = ea;
        {rx_rdy[1], rd_strb[1], tx_mt[1], wr_strb[1], clr_tx_cmd[1], rst_svc_cmd[1], brk_det[1]} = eb;
        @(negedge clk);
        {rx_rdy, rd_strb, tx_mt, wr_strb, clr_tx_cmd, rst_svc_cmd, brk_det} = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        {rx_rdy, rd_strb, tx_mt, wr_strb, clr_tx_cmd, rst_svc_cmd, brk_det} = '0;
        tx_ie = 2'b11; rx_mode = 4'b1001; brk_ie = 2'b00; status_hi = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R1 in reset", 1'b0, 8'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after reset", 1'b0, 8'h00, 8'h00);

        for (int i = 0; i < NT; i++) begin
            step(TBL[i][31:25], TBL[i][24:18], TBL[i][17]);
            chk_all($sformatf("table step %0d", i), TBL[i][16], TBL[i][15:8], TBL[i][7:0]);
        end

        // R2 receive modes 00 and 11 never request
        rx_mode = 4'b1000;
        step(RX, N, 1'b0);
        chk_all("R2 mode00", 1'b0, 8'h0C, 8'h20);
        rx_mode = 4'b1011;
        #1 chk("R2 mode11", "irq", {7'b0, irq}, 8'h00);
        rx_mode = 4'b1001;
        #1 chk("R2 mode01", "irq", {7'b0, irq}, 8'h01);
        @(negedge clk);
        step(RD, N, 1'b0);
        chk_all("R8 read back", 1'b0, 8'h06, 8'h00);

        // R4 transmit enable clear: no pending bit, vector still written
        tx_ie = 2'b10;
        step(TXE, N, 1'b0);
        chk_all("R4 tx disabled", 1'b0, 8'h08, 8'h00);
        tx_ie = 2'b11;
        #1 chk("R2 tx enable", "irq", {7'b0, irq}, 8'h01);
        @(negedge clk);
        step(CLR, N, 1'b0);
        chk_all("R9 clear", 1'b0, 8'h06, 8'h00);

        // R12 transmit-empty beats write; read beats transmit-empty
        step(TXE | WR, N, 1'b0);
        chk_all("R12 txe over wr", 1'b1, 8'h08, 8'h10);
        step(WR, N, 1'b0);
        chk_all("R10 write keeps bit", 1'b0, 8'h08, 8'h10);
        step(CLR, N, 1'b0);
        chk_all("R9 clear again", 1'b0, 8'h06, 8'h00);
        step(RD | TXE, N, 1'b0);
        chk_all("R12 rd over txe", 1'b0, 8'h06, 8'h00);

        // R11 break status and external bits
        step(N, BRK, 1'b0);
        chk_all("R11 brk masked", 1'b0, 8'h06, 8'h00);
        brk_ie = 2'b10;
        #1 chk_all("R11 brk enabled", 1'b1, 8'h06, 8'h01);
        brk_ie = 2'b11;
        @(negedge clk);
        chk_all("R11 sticky, A clear", 1'b1, 8'h06, 8'h01);

        // R1 reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 re-reset", 1'b0, 8'h00, 8'h00);

        finish_run();
    end
endmodule